// File: doc/BRIEF.md
# Token-Ring Multiphase Phase Sequencer

This block produces the switching-start timing for a multiphase power converter. A controller and a set of phase cells run from one shared clock and pass a single phase token around a closed ring: the controller's output feeds cell 0, every cell feeds the next one, and the output of the last cell comes back to the controller. A cell fires a one-clock set pulse for its own PWM in the cycle it holds the token. The active cells therefore fire one clock apart, and each cell fires once every L clocks, where L is the number of cells still in the ring. The clock therefore runs at L times the per-phase switching rate.

After reset the controller sends out one token with every cell in the ring. It counts the clocks until the token comes back, and that count is the number of phases it reports. If the token does not come back within a timeout, the controller raises a sticky loop fault. When the active-low power-state input is low, the cells selected by a drop mask are bypassed: each passes its input straight to its output without a clock of delay and fires no pulse. The controller applies a new mask only between token waves. It holds back one launch and clears every cell, so no stale token is left in the ring. While running, the controller checks every full wave for the token's return, and a missing return is also a loop fault.

Top module: `phase_ring_top`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `pwm_set`, `phase_count`, `loop_fault` and `ring_ready` are all zero.
- R2: Reset is released synchronously through two flops. The token leaves the controller in the cycle after the third rising edge after release. `phase_count` reads N_CELLS (binary) and `ring_ready` is 1 after the eighth edge, and both read 0 after the seventh edge. Discovery always uses the full ring, whatever the values of `psi_n` and `drop_mask`.
- R3: During discovery, `pwm_set[i]` is high alone after edge i+4 for i = 0 .. N_CELLS-1. Bit i belongs to cell i, and cell 0 is the first cell after the controller.
- R4: At most one bit of `pwm_set` is high in any cycle. In steady running with L ≥ 1 live cells, exactly one bit is high in every cycle, and the pulses follow ring order through the live cells (ascending index, wrapping around).
- R5: In steady running, each live cell pulses exactly once every L clocks.
- R6: When `psi_n` is 0, every cell i with `drop_mask[i]` = 1 is bypassed. It never pulses, and it is skipped in the ring order.
- R7: When `psi_n` is 1, `drop_mask` has no effect: every cell stays in the ring.
- R8: If every cell is dropped, `pwm_set` stays 0 and no loop fault is raised.
- R9: If the token has not returned 15 clocks after launch during discovery (TIMEOUT = 16), `loop_fault` rises after edge 19. `phase_count` then reads 0, and `ring_ready` reads 0.
- R10: During running, a break in the ring (`link_ok[i]` = 0 at an in-ring cell) raises `loop_fault` within one wave. The fault is sticky until reset, even after the link is restored, and it stops all further pulses.
- R11: `live_count` equals the number of cells in the applied ring (N_CELLS minus the dropped cells), and it reaches the new value within a few waves after the mask changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psi_n | input | 1 | Power-state input, active low; enables dropping |
| drop_mask | input | N_CELLS | Cells to bypass while psi_n is low |
| link_ok | input | N_CELLS | Per-cell output link intact (0 breaks the ring there) |
| pwm_set | output | N_CELLS | One-clock PWM set pulse per cell |
| phase_count | output | CNT_W | Phase count found at power-up, 0 on fault |
| live_count | output | CNT_W | Cells in the currently applied ring |
| loop_fault | output | 1 | Sticky ring fault |
| ring_ready | output | 1 | Discovery finished without fault |

## Verification
The bound checker watches the pulses on every cycle. It checks that at most one pulse fires and that cell 0 follows the controller's token by one clock whenever cell 0 is live. It also checks that a fault stays set and forces the count to zero, that ready and fault never coincide, that the discovered count stays fixed while the ring is ready, and that the live count never exceeds the cell count. Only the bench's scenarios show the following: the exact discovery latency, the ring order and period for each drop pattern, the settling after a mask change, the timeout edge, and a break during running.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [2:0] {
    ST_LAUNCH = 3'd0,
    ST_WAIT   = 3'd1,
    ST_FLUSH  = 3'd2,
    ST_RUN    = 3'd3,
    ST_FAULT  = 3'd4
  } ring_st_e;
endpackage

// File: rtl/phase_cell.sv
module phase_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic tok_in,
  input  logic bypass,
  input  logic link_ok,
  output logic tok_out,
  output logic pwm_set
);
  logic hold_q;
  logic hold_d;

  always_comb begin
    hold_d = flush ? 1'b0 : tok_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  // bypassed cells forward the token without a clock of delay
  assign tok_out = link_ok & (bypass ? tok_in : hold_q);
  assign pwm_set = hold_q & ~bypass;
endmodule

// File: rtl/ring_ctrl.sv
module ring_ctrl
  import prs_pkg::*;
#(
  parameter int N_CELLS = 4,
  parameter int TIMEOUT = 16,
  parameter int CW      = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psi_n,
  input  logic [N_CELLS-1:0] drop_mask,
  input  logic               ring_ret,
  output logic               tok,
  output logic               flush,
  output logic [N_CELLS-1:0] byp,
  output logic [CW-1:0]      phase_count,
  output logic [CW-1:0]      live_count,
  output logic               fault,
  output logic               ready
);
  ring_st_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] pc_q, pc_d;
  logic [N_CELLS-1:0] byp_q, byp_d, mask_pend;
  logic tok_q, tok_d, armed_q, armed_d, fault_q, fault_d;
  logic [CW:0] cnt_inc;
  logic launch_pt;

  assign mask_pend = psi_n ? '0 : drop_mask;

  always_comb begin
    live_count = '0;
    for (int i = 0; i < N_CELLS; i++)
      live_count = live_count + {{(CW-1){1'b0}}, ~byp_q[i]};
  end

  assign cnt_inc   = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  assign launch_pt = (cnt_inc >= {1'b0, live_count});

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    pc_d    = pc_q;
    byp_d   = byp_q;
    tok_d   = 1'b0;
    armed_d = armed_q;
    fault_d = fault_q;
    case (st_q)
      ST_LAUNCH: begin
        tok_d = 1'b1;
        cnt_d = '0;
        st_d  = ST_WAIT;
      end
      ST_WAIT: begin
        if (ring_ret) begin
          pc_d = cnt_q;
          st_d = ST_FLUSH;
        end else if (cnt_q == CW'(TIMEOUT - 1)) begin
          fault_d = 1'b1;
          pc_d    = '0;
          st_d    = ST_FAULT;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_FLUSH: begin
        byp_d   = mask_pend;
        tok_d   = 1'b1;
        cnt_d   = '0;
        armed_d = 1'b0;
        st_d    = ST_RUN;
      end
      ST_RUN: begin
        if (tok_q) armed_d = 1'b1;
        if (tok_q && armed_q && !ring_ret) begin
          fault_d = 1'b1;
          pc_d    = '0;
          st_d    = ST_FAULT;
        end else if (launch_pt) begin
          if (mask_pend != byp_q) begin
            st_d = ST_FLUSH;
          end else begin
            tok_d = 1'b1;
            cnt_d = '0;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d    = ST_FAULT;
        fault_d = 1'b1;
        pc_d    = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_LAUNCH;
      cnt_q   <= '0;
      pc_q    <= '0;
      byp_q   <= '0;
      tok_q   <= 1'b0;
      armed_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      pc_q    <= pc_d;
      byp_q   <= byp_d;
      tok_q   <= tok_d;
      armed_q <= armed_d;
      fault_q <= fault_d;
    end
  end

  assign tok         = tok_q;
  assign flush       = (st_q == ST_FLUSH);
  assign byp         = byp_q;
  assign phase_count = pc_q;
  assign fault       = fault_q;
  assign ready       = (st_q == ST_FLUSH) || (st_q == ST_RUN);
endmodule

// File: rtl/phase_ring_top.sv
module phase_ring_top #(
  parameter int N_CELLS = 4,
  parameter int TIMEOUT = 16,
  localparam int CNT_W  = $clog2(((TIMEOUT > N_CELLS) ? TIMEOUT : N_CELLS) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               psi_n,
  input  logic [N_CELLS-1:0] drop_mask,
  input  logic [N_CELLS-1:0] link_ok,
  output logic [N_CELLS-1:0] pwm_set,
  output logic [CNT_W-1:0]   phase_count,
  output logic [CNT_W-1:0]   live_count,
  output logic               loop_fault,
  output logic               ring_ready
);
  logic [1:0] rst_sync_q;
  logic rst_int_n;
  logic ctrl_tok, ctrl_flush;
  logic [N_CELLS-1:0] ctrl_byp;
  logic [N_CELLS:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ring_ctrl #(.N_CELLS(N_CELLS), .TIMEOUT(TIMEOUT), .CW(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .psi_n(psi_n), .drop_mask(drop_mask),
    .ring_ret(chain[N_CELLS]), .tok(ctrl_tok), .flush(ctrl_flush),
    .byp(ctrl_byp), .phase_count(phase_count), .live_count(live_count),
    .fault(loop_fault), .ready(ring_ready)
  );

  assign chain[0] = ctrl_tok;

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    phase_cell u_cell (
      .clk(clk), .rst_n(rst_int_n), .flush(ctrl_flush),
      .tok_in(chain[g]), .bypass(ctrl_byp[g]), .link_ok(link_ok[g]),
      .tok_out(chain[g+1]), .pwm_set(pwm_set[g])
    );
  end
endmodule

// File: rtl/phase_ring_chk.sv
module phase_ring_chk #(
  parameter int N_CELLS = 4,
  parameter int CW      = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_CELLS-1:0] pwm_set,
  input logic               tok,
  input logic [N_CELLS-1:0] byp,
  input logic               fault,
  input logic               ready,
  input logic [CW-1:0]      phase_count,
  input logic [CW-1:0]      live_count
);
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pwm_set));

  assert_first_cell_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tok && !byp[0]) |=> (pwm_set[0] || $changed(byp[0])));

  assert_fault_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  assert_fault_zero_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (phase_count == '0));

  assert_ready_excl_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && fault));

  assert_count_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(phase_count));

  assert_live_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    live_count <= CW'(N_CELLS));
endmodule

bind phase_ring_top phase_ring_chk #(.N_CELLS(N_CELLS), .CW(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_int_n), .pwm_set(pwm_set), .tok(ctrl_tok),
  .byp(ctrl_byp), .fault(loop_fault), .ready(ring_ready),
  .phase_count(phase_count), .live_count(live_count)
);

// File: tb/sim_phase_ring_top.sv
`timescale 1ns/1ps
module sim_phase_ring_top;
  localparam int N  = 4;
  localparam int TO = 16;
  localparam int CW = $clog2(TO + 1);

  logic clk, rst_n, psi_n;
  logic [N-1:0] drop_mask, link_ok, pwm_set;
  logic [CW-1:0] phase_count, live_count;
  logic loop_fault, ring_ready;
  int n_tests, n_fail, cyc;

  phase_ring_top #(.N_CELLS(N), .TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .psi_n(psi_n), .drop_mask(drop_mask),
    .link_ok(link_ok), .pwm_set(pwm_set), .phase_count(phase_count),
    .live_count(live_count), .loop_fault(loop_fault), .ring_ready(ring_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int popc(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic int next_live(input int p, input logic [N-1:0] eb);
    for (int k = 1; k <= N; k++) if (!eb[(p + k) % N]) return (p + k) % N;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset(input logic p, input logic [N-1:0] dm, input logic [N-1:0] lk);
    @(negedge clk);
    rst_n = 1'b0; psi_n = p; drop_mask = dm; link_ok = lk;
    step(3);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // observe a steady window and check order, period, dropped cells
  task automatic window(input logic [N-1:0] eb, input string tag);
    int last[N];
    int prev = -1, l = popc(~eb);
    bit ok_cnt = 1, ok_ord = 1, ok_per = 1, ok_drop = 1;
    int bad = 0;
    for (int i = 0; i < N; i++) last[i] = -1;
    for (int t = 0; t < 4 * N + 4; t++) begin
      step(1);
      if (popc(pwm_set) != ((l > 0) ? 1 : 0)) begin ok_cnt = 0; bad = popc(pwm_set); end
      for (int i = 0; i < N; i++) if (pwm_set[i]) begin
        if (eb[i]) ok_drop = 0;
        if (prev >= 0 && i != next_live(prev, eb)) ok_ord = 0;
        if (last[i] >= 0 && (t - last[i]) != l) ok_per = 0;
        last[i] = t; prev = i;
      end
    end
    check(ok_cnt, "R4", {tag, " pulses per cycle"}, bad, (l > 0) ? 1 : 0);
    check(ok_ord, "R4", {tag, " ring order"}, 0, 1);
    check(ok_per, "R5", {tag, " period"}, 0, l);
    check(ok_drop, "R6", {tag, " dropped cell silent"}, 0, 1);
    check(int'(live_count) == l, "R11", {tag, " live_count"}, int'(live_count), l);
    check(!loop_fault, "R8", {tag, " no fault"}, int'(loop_fault), 0);
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] dm, eb;
    logic p;
    n_tests = 0; n_fail = 0; cyc = 0;
    void'($urandom(32'h1d2c3b4a));
    rst_n = 1'b0; psi_n = 1'b1; drop_mask = '0; link_ok = '1;

    // R1 reset state
    step(2);
    check(pwm_set == 0 && phase_count == 0 && !loop_fault && !ring_ready,
          "R1", "outputs in reset", int'(pwm_set), 0);

    // R2 / R3 discovery with dropping requested (must be ignored)
    do_reset(1'b0, '1, '1);
    step(1);
    check(pwm_set == 0 && !ring_ready, "R1", "after release", int'(pwm_set), 0);
    for (int e = 2; e <= 8; e++) begin
      step(1);
      if (e >= 4 && e <= 3 + N)
        check(pwm_set == (N'(1) << (e - 4)), "R3", "discovery pulse", int'(pwm_set), 1 << (e - 4));
      if (e == 7) check(phase_count == 0 && !ring_ready, "R2", "count before edge 8", int'(phase_count), 0);
      if (e == 8) check(int'(phase_count) == N && ring_ready, "R2", "count at edge 8", int'(phase_count), N);
    end
    step(3 * N);
    window('1, "all dropped");
    check(pwm_set == 0, "R8", "all dropped silent", int'(pwm_set), 0);

    // R7 psi high ignores mask
    @(negedge clk); psi_n = 1'b1; drop_mask = 4'b0110;
    step(3 * N + 4);
    window('0, "psi high");

    // R6 directed drop
    @(negedge clk); psi_n = 1'b0; drop_mask = 4'b1010;
    step(3 * N + 4);
    window(4'b1010, "drop 1010");

    // random patterns
    for (int k = 0; k < 12; k++) begin
      p  = 1'($urandom_range(0, 1));
      dm = N'($urandom_range(0, (1 << N) - 1));
      eb = p ? '0 : dm;
      @(negedge clk); psi_n = p; drop_mask = dm;
      step(3 * N + 4);
      window(eb, "random");
      check(int'(phase_count) == N, "R2", "count held", int'(phase_count), N);
    end

    // R10 break during running, sticky after repair
    @(negedge clk); psi_n = 1'b1; drop_mask = '0;
    step(3 * N + 4);
    @(negedge clk); link_ok = 4'b1011;
    step(2 * N + 4);
    check(loop_fault && phase_count == 0 && !ring_ready, "R10", "break raises fault", int'(loop_fault), 1);
    @(negedge clk); link_ok = '1;
    step(2 * N);
    begin
      bit quiet = 1;
      for (int t = 0; t < 3 * N; t++) begin step(1); if (pwm_set != 0 || !loop_fault) quiet = 0; end
      check(quiet, "R10", "fault sticky and silent", int'(pwm_set), 0);
    end

    // R9 timeout at power-up
    do_reset(1'b1, '0, 4'b1101);
    step(18);
    check(!loop_fault, "R9", "no fault at edge 18", int'(loop_fault), 0);
    step(1);
    check(loop_fault && phase_count == 0 && !ring_ready, "R9", "fault at edge 19", int'(loop_fault), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule